// File: doc/BRIEF.md
# Pulse-Position Forward Link Modulator

This block turns a reader-to-tag command into a timed waveform on one active-high modulation output. Each 2-bit symbol fixes where a single short pulse falls inside a slot. A frame is an unmodulated lead-in, a fixed two-pulse start pattern, one slot per symbol and a closing pulse. Every interval is a count of reference clock cycles, with the reference taken as 16 MHz. All gap lengths come from one shared seven-entry interval table: 81, 238, 384, 531, 679, 825 and 972 clocks, at indices 0 to 6.

The user presents a symbol count and a supported mode code, then pulses `start_i` while the block is idle. The block reads command bytes from outside through a byte index output. Each byte holds four symbols. The block raises `busy_o` for the whole frame and drops it together with the modulation output at the end.

The control state machine has these states:
- `ST_IDLE`
- `ST_LEAD` (256-clock unmodulated lead-in)
- `ST_SOF_MOD1`, `ST_SOF_REL1`, `ST_SOF_MOD2`, `ST_SOF_REL2` (start pattern)
- `ST_SLOT_PRE` (released gap before the symbol pulse)
- `ST_SLOT_MOD` (81-clock symbol pulse)
- `ST_SLOT_POST` (released tail after the pulse)
- `ST_EOF_REL`, `ST_EOF_MOD` (closing gap and closing pulse)

Transitions, each taken when the current interval expires unless noted:
- IDLE→LEAD when an accepted start arrives.
- LEAD→SOF_MOD1→SOF_REL1→SOF_MOD2→SOF_REL2.
- SOF_REL2→SLOT_PRE, or →EOF_REL when no symbols remain.
- SLOT_PRE→SLOT_MOD.
- SLOT_MOD→SLOT_POST for symbols 0 to 2. For symbol 3 it goes straight to SLOT_PRE of the next symbol, or to EOF_REL.
- SLOT_POST→SLOT_PRE, or →EOF_REL when no symbols remain.
- EOF_REL→EOF_MOD→IDLE.

Top module: `ppm_fwd_link`

## Requirements
- R1: After reset `busy_o` and `mod_o` are both 0.
- R2: A start accepted in idle with `mode_i` equal to 1 sets `busy_o` in the next cycle. `mod_o` then stays 0 for exactly 256 cycles.
- R3: After the lead-in, the start pattern drives `mod_o` high for 81 cycles, low for 531, high for 81, then low for 238 cycles. The first symbol slot begins after these 238 cycles.
- R4: A symbol of value s gives `mod_o` low for table[2s] cycles, then high for 81 cycles. For s of 0, 1 or 2 it adds a low tail of table[5-2s] cycles; for s = 3 the next symbol follows at once. The table is 81, 238, 384, 531, 679, 825, 972 at indices 0 to 6.
- R5: Symbol k is taken from byte k/4, presented on `sym_byte_i` while `byte_idx_o` equals k/4. It uses bits [2(k mod 4)+1 : 2(k mod 4)], so bits [1:0] are sent first.
- R6: After the last symbol, `mod_o` stays low for 238 cycles, then goes high for 81 cycles. `mod_o` and `busy_o` then fall in the same cycle.
- R7: A symbol count of 0 produces the lead-in, the start pattern and the closing sequence only.
- R8: A start with `mode_i` other than 1 is ignored: `busy_o` and `mod_o` stay 0.
- R9: A start while busy is ignored. The symbol count is latched when a start is accepted, so later changes to `sym_count_i` do not alter the frame.
- R10: Every high phase of `mod_o` lasts exactly 81 cycles.
- R11: `mod_o` is 0 whenever `busy_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame start request |
| mode_i | input | MODE_W | Modulation type code; 1 is the only supported value |
| sym_count_i | input | SYM_CNT_W | Number of 2-bit symbols in the frame |
| sym_byte_i | input | 8 | Command byte selected by `byte_idx_o` |
| byte_idx_o | output | SYM_CNT_W-2 | Index of the byte holding the current symbol |
| busy_o | output | 1 | High while a frame is being sent |
| mod_o | output | 1 | Modulation output, active high |

## Verification
The bench builds the expected waveform from the requirements as a list of high and low run lengths. Adjacent low gaps are merged, such as a start-pattern tail followed by a symbol's leading gap. This catches a design that double-counts or drops a cycle at a state boundary.

Frames with every symbol value, symbols taken across byte boundaries, and an empty frame expose three faults:
- a wrong table index, which changes a run length;
- an extra tail after symbol 3, which shows up as a lengthened gap;
- pairs taken from the wrong end of a byte, which reorders the runs.

An unsupported mode code and a start during a frame that also changes the count expose a design that starts anyway, restarts mid-frame or reads the live count. Any of these adds runs or alters them.

// File: rtl/ppm_fwd_pkg.sv
package ppm_fwd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SOF_MOD1,
        ST_SOF_REL1,
        ST_SOF_MOD2,
        ST_SOF_REL2,
        ST_SLOT_PRE,
        ST_SLOT_MOD,
        ST_SLOT_POST,
        ST_EOF_REL,
        ST_EOF_MOD
    } ppm_state_e;

    localparam int unsigned LEAD_CLKS  = 256;
    localparam int unsigned PULSE_CLKS = 81;

    // shared interval table, reference clocks
    function automatic int unsigned gap_clks(input int unsigned idx);
        int unsigned v;
        case (idx)
            0:       v = 81;
            1:       v = 238;
            2:       v = 384;
            3:       v = 531;
            4:       v = 679;
            5:       v = 825;
            default: v = 972;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/ppm_interval_timer.sv
module ppm_interval_timer #(
    parameter int unsigned TIMER_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [TIMER_W-1:0] load_val,
    output logic               expired
);

    logic [TIMER_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load) begin
            remain_q <= load_val;
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign expired = (remain_q == '0);

endmodule

// File: rtl/ppm_sym_fetch.sv
module ppm_sym_fetch #(
    parameter int unsigned SYM_CNT_W  = 8,
    localparam int unsigned BYTE_IDX_W = SYM_CNT_W - 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  capture,
    input  logic [SYM_CNT_W-1:0]  count_in,
    input  logic                  advance,
    input  logic [7:0]            byte_data,
    output logic [BYTE_IDX_W-1:0] byte_idx,
    output logic [1:0]            sym,
    output logic                  exhausted
);

    logic [SYM_CNT_W-1:0] pos_q;
    logic [SYM_CNT_W-1:0] total_q;
    logic [7:0]           shifted;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q   <= '0;
            total_q <= '0;
        end else if (capture) begin
            pos_q   <= '0;
            total_q <= count_in;
        end else if (advance) begin
            pos_q   <= pos_q + 1'b1;
        end
    end

    always_comb begin
        shifted = byte_data >> {pos_q[1:0], 1'b0};
        sym     = shifted[1:0];
    end

    assign byte_idx  = pos_q[SYM_CNT_W-1:2];
    assign exhausted = (pos_q == total_q);

endmodule

// File: rtl/ppm_fwd_link.sv
module ppm_fwd_link
    import ppm_fwd_pkg::*;
#(
    parameter int unsigned SYM_CNT_W = 8,
    parameter int unsigned MODE_W    = 2,
    parameter int unsigned MODE_PPM  = 1,
    parameter int unsigned TIMER_W   = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [MODE_W-1:0]    mode_i,
    input  logic [SYM_CNT_W-1:0] sym_count_i,
    input  logic [7:0]           sym_byte_i,
    output logic [SYM_CNT_W-3:0] byte_idx_o,
    output logic                 busy_o,
    output logic                 mod_o
);

    ppm_state_e         state_q, state_d;
    logic [1:0]         cur_sym_q, cur_sym_d;
    logic               t_load, t_done;
    logic [TIMER_W-1:0] t_val;
    logic               f_cap, f_adv, f_empty;
    logic [1:0]         f_sym;

    // next entry into the data phase: another slot or the closing gap
    ppm_state_e         ent_state;
    logic [TIMER_W-1:0] ent_val;

    function automatic logic [TIMER_W-1:0] span(input int unsigned n);
        return TIMER_W'(n - 1);
    endfunction

    ppm_interval_timer #(.TIMER_W(TIMER_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_done)
    );

    ppm_sym_fetch #(.SYM_CNT_W(SYM_CNT_W)) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (f_cap),
        .count_in  (sym_count_i),
        .advance   (f_adv),
        .byte_data (sym_byte_i),
        .byte_idx  (byte_idx_o),
        .sym       (f_sym),
        .exhausted (f_empty)
    );

    always_comb begin
        if (f_empty) begin
            ent_state = ST_EOF_REL;
            ent_val   = span(gap_clks(1));
        end else begin
            ent_state = ST_SLOT_PRE;
            ent_val   = span(gap_clks(2 * int'(f_sym)));
        end
    end

    always_comb begin
        state_d   = state_q;
        cur_sym_d = cur_sym_q;
        t_load    = 1'b0;
        t_val     = '0;
        f_cap     = 1'b0;
        f_adv     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i && (mode_i == MODE_W'(MODE_PPM))) begin
                    state_d = ST_LEAD;
                    t_load  = 1'b1;
                    t_val   = span(LEAD_CLKS);
                    f_cap   = 1'b1;
                end
            end
            ST_LEAD: if (t_done) begin
                state_d = ST_SOF_MOD1;
                t_load  = 1'b1;
                t_val   = span(PULSE_CLKS);
            end
            ST_SOF_MOD1: if (t_done) begin
                state_d = ST_SOF_REL1;
                t_load  = 1'b1;
                t_val   = span(gap_clks(3));
            end
            ST_SOF_REL1: if (t_done) begin
                state_d = ST_SOF_MOD2;
                t_load  = 1'b1;
                t_val   = span(PULSE_CLKS);
            end
            ST_SOF_MOD2: if (t_done) begin
                state_d = ST_SOF_REL2;
                t_load  = 1'b1;
                t_val   = span(gap_clks(1));
            end
            ST_SOF_REL2, ST_SLOT_POST: if (t_done) begin
                state_d   = ent_state;
                t_load    = 1'b1;
                t_val     = ent_val;
                cur_sym_d = f_sym;
            end
            ST_SLOT_PRE: if (t_done) begin
                state_d = ST_SLOT_MOD;
                t_load  = 1'b1;
                t_val   = span(PULSE_CLKS);
                f_adv   = 1'b1;
            end
            ST_SLOT_MOD: if (t_done) begin
                if (cur_sym_q == 2'd3) begin
                    state_d   = ent_state;
                    t_load    = 1'b1;
                    t_val     = ent_val;
                    cur_sym_d = f_sym;
                end else begin
                    state_d = ST_SLOT_POST;
                    t_load  = 1'b1;
                    t_val   = span(gap_clks(5 - 2 * int'(cur_sym_q)));
                end
            end
            ST_EOF_REL: if (t_done) begin
                state_d = ST_EOF_MOD;
                t_load  = 1'b1;
                t_val   = span(PULSE_CLKS);
            end
            ST_EOF_MOD: if (t_done) begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            cur_sym_q <= 2'd0;
        end else begin
            state_q   <= state_d;
            cur_sym_q <= cur_sym_d;
        end
    end

    always_comb begin
        busy_o = (state_q != ST_IDLE);
        unique case (state_q)
            ST_SOF_MOD1, ST_SOF_MOD2, ST_SLOT_MOD, ST_EOF_MOD: mod_o = 1'b1;
            default:                                           mod_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/ppm_fwd_link_chk.sv
module ppm_fwd_link_chk #(
    parameter int unsigned MODE_W   = 2,
    parameter int unsigned MODE_PPM = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              busy_o,
    input logic              mod_o
);

    logic [7:0] hi_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    hi_run <= '0;
        else if (!mod_o)               hi_run <= '0;
        else if (hi_run != 8'hFF)      hi_run <= hi_run + 1'b1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mod_o);  // R11

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mod_o) |-> (hi_run == 8'd81));  // R10

    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (mode_i == MODE_W'(MODE_PPM))) |=> busy_o);  // R2

    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i && (mode_i != MODE_W'(MODE_PPM))) |=> !busy_o);  // R8

    AST_LEAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !mod_o);  // R2

    AST_END_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(mod_o));  // R6

endmodule

bind ppm_fwd_link ppm_fwd_link_chk #(.MODE_W(MODE_W), .MODE_PPM(MODE_PPM)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .busy_o  (busy_o),
    .mod_o   (mod_o)
);

// File: tb/ppm_fwd_link_test.sv
module ppm_fwd_link_test;

    typedef struct {
        bit    lvl;
        int    len;
        string tag;
    } run_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [1:0] mode_i = 2'd1;
    logic [7:0] sym_count_i = '0;
    logic [7:0] sym_byte_i;
    logic [5:0] byte_idx_o;
    logic       busy_o, mod_o;

    logic [7:0] mem [64];
    run_t       exp_q [$];
    int         n_checks = 0;
    int         n_fail = 0;
    int         cycles = 0;

    bit    pend_v = 0;
    bit    pend_lvl;
    int    pend_len;
    string pend_tag;

    bit    in_run = 0;
    bit    cur_lvl;
    int    cur_len;
    bit    mon_en = 0;

    always #4 clk = ~clk;

    assign sym_byte_i = mem[byte_idx_o];

    ppm_fwd_link uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .sym_count_i (sym_count_i),
        .sym_byte_i  (sym_byte_i),
        .byte_idx_o  (byte_idx_o),
        .busy_o      (busy_o),
        .mod_o       (mod_o)
    );

    function automatic int tbl(input int i);
        int t [7] = '{81, 238, 384, 531, 679, 825, 972};
        return t[i];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic add_seg(input bit lvl, input int len, input string tag);
        if (pend_v && pend_lvl == lvl) begin
            pend_len += len;
        end else begin
            if (pend_v) exp_q.push_back('{pend_lvl, pend_len, pend_tag});
            pend_v = 1; pend_lvl = lvl; pend_len = len; pend_tag = tag;
        end
    endtask

    task automatic flush_seg();
        if (pend_v) exp_q.push_back('{pend_lvl, pend_len, pend_tag});
        pend_v = 0;
    endtask

    task automatic close_run();
        run_t e;
        if (exp_q.size() == 0) begin
            check(0, "R9 unexpected run", cur_len, 0);
        end else begin
            e = exp_q.pop_front();
            check(e.lvl == cur_lvl, e.tag, int'(cur_lvl), int'(e.lvl));
            check(e.len == cur_len, e.tag, cur_len, e.len);
        end
    endtask

    // monitor: measures runs of mod_o while busy
    always @(negedge clk) begin
        if (mon_en) begin
            if (busy_o) begin
                if (!in_run) begin
                    in_run = 1; cur_lvl = mod_o; cur_len = 1;
                end else if (mod_o == cur_lvl) begin
                    cur_len++;
                end else begin
                    close_run();
                    cur_lvl = mod_o; cur_len = 1;
                end
            end else if (in_run) begin
                close_run();
                in_run = 0;
            end
        end
    end

    // driver: expected runs, then start pulse
    task automatic send_frame(input int cnt);
        string etag;
        etag = (cnt == 0) ? "R7" : "R6";
        add_seg(0, 256, "R2");
        add_seg(1, 81, "R3");
        add_seg(0, 531, "R3");
        add_seg(1, 81, "R3");
        add_seg(0, 238, "R3");
        for (int k = 0; k < cnt; k++) begin
            int s;
            s = (mem[k / 4] >> (2 * (k % 4))) & 3;
            add_seg(0, tbl(2 * s), "R4");
            add_seg(1, 81, "R5");
            if (s != 3) add_seg(0, tbl(5 - 2 * s), "R4");
        end
        add_seg(0, 238, etag);
        add_seg(1, 81, etag);
        flush_seg();
        sym_count_i = 8'(cnt);
        mode_i = 2'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R2 busy after start", int'(busy_o), 1);
    endtask

    task automatic wait_done(input string tag);
        while (busy_o) @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (busy_o || mod_o) begin
                check(0, "R9 activity after frame", int'(busy_o), 0);
                break;
            end
            @(negedge clk);
        end
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic bad_mode(input logic [1:0] m);
        int act = 0;
        mode_i = m;
        sym_count_i = 8'd4;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (busy_o || mod_o) act++;
            @(negedge clk);
        end
        check(act == 0, "R8 unsupported mode", act, 0);
        mode_i = 2'd1;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'h00;
        mem[0] = 8'hE4;  // symbols 0,1,2,3
        mem[1] = 8'h1B;  // symbols 3,2,1,0
        mem[2] = 8'hFF;
        repeat (3) @(negedge clk);
        check(busy_o === 1'b0 && mod_o === 1'b0, "R1 reset outputs", int'(mod_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o === 1'b0 && mod_o === 1'b0, "R1 after reset", int'(busy_o), 0);
        mon_en = 1;

        send_frame(0);                 // R7
        wait_done("R7 empty frame");

        bad_mode(2'd2);                // R8
        bad_mode(2'd0);

        send_frame(4);                 // R4, R5 within one byte
        wait_done("R4 single byte frame");

        send_frame(10);                // R5 across bytes
        wait_done("R5 multi byte frame");

        send_frame(6);                 // R9 start during frame, count change
        repeat (3000) @(negedge clk);
        sym_count_i = 8'd1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        wait_done("R9 start ignored while busy");

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule